// File: doc/BRIEF.md
# Flag-Conditioned Commit Stage

This is the last pipeline stage of a small 16-bit processor. Each cycle it takes one instruction together with a 6-bit condition control word and its ALU result. It tests the condition against the zero (Z) and carry (C) flags it holds, and decides whether the instruction commits. A non-branch instruction that commits produces a one-cycle register-file write request. A branch that commits produces a one-cycle taken pulse and a redirect address. Committed flag-producing instructions refresh Z and C.

The condition word packs an enable bit, a Z test, a combiner and a C test. Each test can demand 0, demand 1, or ignore its flag, and the combiner joins the two test results with AND or OR. For branch instructions the stage builds the word itself from the selector field of the instruction. Every other instruction uses the word supplied by the decoder.

Top module: `cond_commit_stage`

## Requirements
- R1: Bit positions of the condition word, from bit 5 down to bit 0, are: enable, Z test (2 bits, 4:3), combiner (bit 2), C test (2 bits, 1:0). With enable = 0 nothing commits, whatever the flags or the other bits hold.
- R2: A flag test of 00 passes when the flag is 0. A test of 01 passes when the flag is 1. A test of 10 or 11 always passes.
- R3: Combiner = 1 commits only when both tests pass. Combiner = 0 commits when at least one test passes.
- R4: The word 6'b110010 commits under all four flag combinations.
- R5: An instruction whose bits 15:12 are 0110 is a branch. Its condition comes from selector bits 11:9, and the cond_word input is ignored. The selectors mean: 000 Z=1 and C=0; 001 Z=0; 010 Z=0 and C=0; 011 Z=1 or C=0; 100 Z=0 and C=1; 101 Z=1 or C=1.
- R6: Branch selectors 110 and 111 are taken under every flag combination.
- R7: A committed branch raises br_taken for exactly the following cycle, with br_target equal to pc plus the sign-extended bits 7:0 of the instruction (mod 2^16). A branch never raises wr_en.
- R8: A committed non-branch instruction raises wr_en for exactly the following cycle, with wr_idx equal to dest_idx and wr_data equal to alu_result. A non-branch instruction never raises br_taken.
- R9: Z becomes (alu_result == 0) and C becomes alu_carry only when a committed non-branch instruction has flag_wr = 1. In every other case the flags keep their values, including for a taken branch with flag_wr = 1.
- R10: The condition is tested against the registered flags. Flags produced by the instruction in the same cycle have no effect on its own commit decision.
- R11: A synchronous active-high rst clears flag_z, flag_c, wr_en and br_taken at the next edge.
- R12: While stage_en is 0, flag_z and flag_c hold, and wr_en and br_taken are 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_en | input | 1 | Stage enable; low freezes the flags and suppresses commits |
| instr | input | 16 | Instruction word (branch detection, selector, offset) |
| pc | input | 16 | Address of the instruction |
| cond_word | input | 6 | Condition control word for non-branch instructions |
| flag_wr | input | 1 | Instruction produces flags |
| alu_result | input | 16 | ALU result, also the writeback data |
| alu_carry | input | 1 | Carry out of the ALU |
| dest_idx | input | 3 | Destination register index |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| wr_en | output | 1 | Register-file write pulse |
| wr_idx | output | 3 | Register index for the write |
| wr_data | output | 16 | Data for the write |
| br_taken | output | 1 | Branch-taken pulse |
| br_target | output | 16 | Redirect address |

## Verification
Every cycle, the assertions check these properties: a write and a taken branch never occur together; stalls freeze the flags and drop both pulses; a disabled word never writes; the always word always writes; branches leave the flags untouched; reset clears the state. Only the bench scenarios can show that the truth table is right. It checks all 64 condition words under each flag pair, each branch selector against every flag combination, the sign extension of forward and backward offsets, and that an instruction is judged by the old flags and not by the ones it produces.

// File: rtl/cond_commit_stage.sv
module cond_commit_stage #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int RIDX = 3,
  parameter int OFFW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stage_en,
  input  logic [15:0]     instr,
  input  logic [AW-1:0]   pc,
  input  logic [5:0]      cond_word,
  input  logic            flag_wr,
  input  logic [DW-1:0]   alu_result,
  input  logic            alu_carry,
  input  logic [RIDX-1:0] dest_idx,
  output logic            flag_z,
  output logic            flag_c,
  output logic            wr_en,
  output logic [RIDX-1:0] wr_idx,
  output logic [DW-1:0]   wr_data,
  output logic            br_taken,
  output logic [AW-1:0]   br_target
);

  localparam logic [5:0] W_ALWAYS = 6'b1_10_0_10;
  localparam logic [3:0] OP_BRANCH = 4'b0110;

  function automatic logic test_ok(input logic [1:0] t, input logic f);
    return t[1] | (f == t[0]);
  endfunction

  logic       is_br;
  logic [2:0] br_sel;
  logic [5:0] br_word;
  logic [5:0] eff;
  logic       z_ok, c_ok, pass;
  logic       do_wr, do_br;
  logic [AW-1:0] target;

  assign is_br  = instr[15:12] == OP_BRANCH;
  assign br_sel = instr[11:9];

  always_comb begin
    case (br_sel)
      3'd0:    br_word = 6'b1_01_1_00;
      3'd1:    br_word = 6'b1_00_1_10;
      3'd2:    br_word = 6'b1_00_1_00;
      3'd3:    br_word = 6'b1_01_0_00;
      3'd4:    br_word = 6'b1_00_1_01;
      3'd5:    br_word = 6'b1_01_0_01;
      default: br_word = W_ALWAYS;
    endcase
  end

  assign eff    = is_br ? br_word : cond_word;
  assign z_ok   = test_ok(eff[4:3], flag_z);
  assign c_ok   = test_ok(eff[1:0], flag_c);
  assign pass   = eff[5] & (eff[2] ? (z_ok & c_ok) : (z_ok | c_ok));
  assign do_wr  = pass & ~is_br;
  assign do_br  = pass & is_br;
  assign target = pc + {{(AW-OFFW){instr[OFFW-1]}}, instr[OFFW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      wr_en     <= 1'b0;
      br_taken  <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      br_target <= '0;
    end else if (!stage_en) begin
      wr_en    <= 1'b0;
      br_taken <= 1'b0;
    end else begin
      wr_en    <= do_wr;
      br_taken <= do_br;
      if (do_wr) begin
        wr_idx  <= dest_idx;
        wr_data <= alu_result;
        if (flag_wr) begin
          flag_z <= (alu_result == '0);
          flag_c <= alu_carry;
        end
      end
      if (do_br) br_target <= target;
    end
  end

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (!flag_z && !flag_c && !wr_en && !br_taken));

  a_r12_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !stage_en |=> $stable({flag_z, flag_c}));

  a_r12_pulses_off: assert property (@(posedge clk) disable iff (rst)
    !stage_en |=> (!wr_en && !br_taken));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && br_taken));

  a_r1_disabled_no_write: assert property (@(posedge clk) disable iff (rst)
    (stage_en && !is_br && !cond_word[5]) |=> !wr_en);

  a_r4_always_writes: assert property (@(posedge clk) disable iff (rst)
    (stage_en && !is_br && cond_word == W_ALWAYS) |=> wr_en);

  a_r9_branch_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    (stage_en && is_br) |=> $stable({flag_z, flag_c}));

  a_r6_branch_always_taken: assert property (@(posedge clk) disable iff (rst)
    (stage_en && is_br && br_sel[2:1] == 2'b11) |=> br_taken);

endmodule

// File: tb/tb_cond_commit_stage.sv
module tb_cond_commit_stage;
  logic        clk = 1'b0;
  logic        rst, stage_en, flag_wr, alu_carry;
  logic [15:0] instr, pc, alu_result;
  logic [5:0]  cond_word;
  logic [2:0]  dest_idx;
  logic        flag_z, flag_c, wr_en, br_taken;
  logic [2:0]  wr_idx;
  logic [15:0] wr_data, br_target;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cond_commit_stage dut (
    .clk(clk), .rst(rst), .stage_en(stage_en), .instr(instr), .pc(pc),
    .cond_word(cond_word), .flag_wr(flag_wr), .alu_result(alu_result),
    .alu_carry(alu_carry), .dest_idx(dest_idx), .flag_z(flag_z),
    .flag_c(flag_c), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .br_taken(br_taken), .br_target(br_target));

  // taken pattern per branch selector, bit index = {Z,C}
  localparam logic [3:0] BR_EXP [8] = '{4'b0100, 4'b0011, 4'b0001, 4'b1101,
                                       4'b0010, 4'b1110, 4'b1111, 4'b1111};
  localparam logic [15:0] ALU_OP = 16'h1000;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] i, input logic [5:0] w, input logic fw,
                      input logic [15:0] res, input logic cy, input logic [2:0] d);
    @(negedge clk);
    instr = i; cond_word = w; flag_wr = fw; alu_result = res; alu_carry = cy; dest_idx = d;
    @(posedge clk);
    #1;
  endtask

  task automatic set_flags(input logic z, input logic c);
    step(ALU_OP, 6'b110010, 1'b1, z ? 16'h0000 : 16'h0005, c, 3'd0);
  endtask

  function automatic logic model(input logic [5:0] w, input logic z, input logic c);
    logic zt, ct;
    zt = w[4] ? 1'b1 : (z == w[3]);
    ct = w[1] ? 1'b1 : (c == w[0]);
    return w[5] & (w[2] ? (zt & ct) : (zt | ct));
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; stage_en = 1; instr = ALU_OP; pc = 16'h0100; cond_word = 0;
    flag_wr = 0; alu_result = 0; alu_carry = 0; dest_idx = 0;
    @(posedge clk); @(posedge clk); #1;
    check("R11 reset z", flag_z, 0);
    check("R11 reset c", flag_c, 0);
    check("R11 reset wr_en", wr_en, 0);
    check("R11 reset br_taken", br_taken, 0);
    @(negedge clk); rst = 0;

    // R1 R2 R3 R4: every word under every flag pair
    for (int f = 0; f < 4; f++) begin
      for (int w = 0; w < 64; w++) begin
        set_flags(f[1], f[0]);
        step(ALU_OP, w[5:0], 1'b0, 16'hA5A5, 1'b0, 3'd5);
        check($sformatf("R1/R2/R3 word=%b z=%0d c=%0d", w[5:0], f[1], f[0]),
              wr_en, model(w[5:0], f[1], f[0]));
        check("R8 no br_taken for non-branch", br_taken, 0);
        if (w == 6'b110010) check("R4 always word", wr_en, 1);
      end
    end

    // R5 R6 R7: branch table, cond_word set to disabled to show it is ignored
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 4; f++) begin
        set_flags(f[1], f[0]);
        step({4'b0110, s[2:0], 1'b0, 8'h10}, 6'b000000, 1'b0, 16'h0, 1'b0, 3'd0);
        check($sformatf("R5/R6 sel=%0d zc=%0d", s, f), br_taken, BR_EXP[s][f]);
        check("R7 branch no write", wr_en, 0);
      end
    end

    // R7 target sign extension and pulse width
    set_flags(1'b0, 1'b0);
    pc = 16'h0100;
    step({4'b0110, 3'b111, 1'b0, 8'hF0}, 6'b0, 1'b0, 16'h0, 1'b0, 3'd0);
    check("R7 backward target", br_target, 16'h00F0);
    check("R7 taken", br_taken, 1);
    step(ALU_OP, 6'b000000, 1'b0, 16'h0, 1'b0, 3'd0);
    check("R7 one-cycle pulse", br_taken, 0);
    step({4'b0110, 3'b111, 1'b0, 8'h7F}, 6'b0, 1'b0, 16'h0, 1'b0, 3'd0);
    check("R7 forward target", br_target, 16'h017F);

    // R8 write data and index
    step(ALU_OP, 6'b110010, 1'b0, 16'hBEEF, 1'b0, 3'd6);
    check("R8 wr_en", wr_en, 1);
    check("R8 wr_idx", wr_idx, 6);
    check("R8 wr_data", wr_data, 16'hBEEF);
    step(ALU_OP, 6'b000000, 1'b0, 16'h1234, 1'b0, 3'd1);
    check("R8 one-cycle write", wr_en, 0);

    // R9 flag update and branch leaves flags alone
    set_flags(1'b1, 1'b1);
    check("R9 z set", flag_z, 1);
    check("R9 c set", flag_c, 1);
    step({4'b0110, 3'b111, 1'b0, 8'h01}, 6'b0, 1'b1, 16'h0005, 1'b0, 3'd0);
    check("R9 branch keeps z", flag_z, 1);
    check("R9 branch keeps c", flag_c, 1);
    step(ALU_OP, 6'b110010, 1'b0, 16'h0005, 1'b0, 3'd0);
    check("R9 flag_wr=0 keeps z", flag_z, 1);
    step(ALU_OP, 6'b000000, 1'b1, 16'h0005, 1'b0, 3'd0);
    check("R9 uncommitted keeps z", flag_z, 1);

    // R10 same-cycle flags not visible
    set_flags(1'b0, 1'b0);
    step(ALU_OP, 6'b1_01_1_10, 1'b1, 16'h0000, 1'b1, 3'd2);
    check("R10 not committed on own flags", wr_en, 0);
    check("R10 z unchanged", flag_z, 0);

    // R12 stall
    step(ALU_OP, 6'b110010, 1'b1, 16'h0000, 1'b1, 3'd2);
    check("R12 pre-stall write", wr_en, 1);
    @(negedge clk); stage_en = 0;
    step(ALU_OP, 6'b110010, 1'b1, 16'h0007, 1'b0, 3'd3);
    check("R12 wr_en low", wr_en, 0);
    check("R12 z held", flag_z, 1);
    check("R12 c held", flag_c, 1);
    step({4'b0110, 3'b111, 1'b0, 8'h01}, 6'b0, 1'b0, 16'h0, 1'b0, 3'd0);
    check("R12 br_taken low", br_taken, 0);
    @(negedge clk); stage_en = 1;

    // R11 mid-run reset
    set_flags(1'b1, 1'b1);
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    check("R11 mid reset z", flag_z, 0);
    check("R11 mid reset c", flag_c, 0);
    check("R11 mid reset wr_en", wr_en, 0);
    @(negedge clk); rst = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule